// File: doc/BRIEF.md
# High/Low Multiply Pair Fuser

This block sits in an in-order decode stage and looks at two adjacent 32-bit RV32 instruction slots in the same cycle. It searches for one idiom: an upper-half multiply followed at once by a lower-half multiply of the same operands. The upper-half multiply may be signed by signed, unsigned by unsigned, or signed by unsigned. When it finds that pair, both products can come from one multiplier pass. The block then issues one fused micro-op that names both destination registers and the signedness of the upper half, and it reports that two slots were used.

In every other case the older slot passes through alone and is reported as one slot used. The lower product does not depend on which upper variant is present, so the mode field only selects how the upper half is computed. Every result is registered and appears one clock after the slots are presented.

Top module: `mulf_fuse_top`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, every output is zero on the next cycle.
- R2: `out_valid` equals `slot0_valid` from the previous edge. When `out_valid` is 0, `out_consume` is 0.
- R3: An upper multiply with opcode 0110011, funct7 0000001 and funct3 001, followed by a lower multiply with funct3 000, fuses when both slots are valid. The result is `out_fused`=1, `out_consume`=2, `out_mode`=00, `out_rd_hi` set to the first instruction's rd (bits 11:7) and `out_rd_lo` set to the second instruction's rd.
- R4: An unsigned-by-unsigned upper multiply (funct3 011) fuses with `out_mode`=01.
- R5: A signed-by-unsigned upper multiply (funct3 010) fuses with `out_mode`=10.
- R6: Fusion needs rs1 (bits 19:15) and rs2 (bits 24:20) to be equal in both slots, in the same order. Swapped or different sources do not fuse.
- R7: The pair does not fuse if the upper multiply's rd equals either of its source registers.
- R8: With `slot1_valid` low, the pair does not fuse and `out_consume` is 1 when slot 0 is valid.
- R9: The reverse order (lower then upper) does not fuse. Any slot whose opcode, funct7 or funct3 is outside the pattern also does not fuse.
- R10: A matching pair whose lower rd is x0 still fuses, with `out_lo_wr`=0. Otherwise a fused op has `out_lo_wr`=1.
- R11: `out_instr` carries the slot-0 instruction whenever slot 0 was valid. A non-fused output has `out_consume`=1, `out_rd_hi`=0, `out_rd_lo`=0, `out_mode`=00 and `out_lo_wr`=0.
- R12: With `slot0_valid` low, nothing is issued and all outputs are zero, whatever slot 1 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot0_valid | input | 1 | Older decode slot holds an instruction |
| slot0_instr | input | 32 | Older instruction |
| slot1_valid | input | 1 | Younger decode slot holds an instruction |
| slot1_instr | input | 32 | Younger instruction |
| out_valid | output | 1 | A micro-op is issued |
| out_fused | output | 1 | The issued micro-op is the fused pair |
| out_consume | output | 2 | Slots consumed: 0, 1 or 2 |
| out_instr | output | 32 | Slot-0 instruction carried with the micro-op |
| out_rd_hi | output | 5 | Destination of the upper product (fused only) |
| out_rd_lo | output | 5 | Destination of the lower product (fused only) |
| out_mode | output | 2 | Upper signedness: 00 s×s, 01 u×u, 10 s×u |
| out_lo_wr | output | 1 | Lower product is written (fused and rd_lo not x0) |

## Verification
All outputs come from a single register stage, so every result is due exactly one rising edge after the slot contents it depends on. The bench drives new slot contents on the falling edge. On the next falling edge it compares every output against the value its behavioural model computed from the slots it had just driven, which is exactly one register delay later. Directed pairs cover each mode, aliasing and order case. Random pairs drawn from a small register pool make chance matches and near misses common.

// File: rtl/mulf_pkg.sv
// Shared widths and types for the multiply-pair fuser.
// Assumes 32-bit base instructions with 5-bit register indices.
package mulf_pkg;
    localparam int ILEN   = 32;
    localparam int RIDX_W = 5;
    localparam int F3_W   = 3;

    localparam logic [6:0] OP_REG   = 7'b0110011;
    localparam logic [6:0] F7_MULDV = 7'b0000001;

    typedef enum logic [1:0] {
        MODE_SS = 2'b00,
        MODE_UU = 2'b01,
        MODE_SU = 2'b10
    } hmode_e;

    typedef struct packed {
        logic              muldv;
        logic [F3_W-1:0]   f3;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs1;
        logic [RIDX_W-1:0] rs2;
    } mdec_t;
endpackage

// File: rtl/mulf_decode.sv
// Field extractor for one slot: flags the multiply/divide group and
// splits out funct3 and the register indices. Purely combinational.
module mulf_decode
    import mulf_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output mdec_t           dec
);
    // Split fields and classify the opcode/funct7 group.
    always_comb begin
        dec.muldv = (instr[6:0] == OP_REG) && (instr[31:25] == F7_MULDV);
        dec.f3    = instr[14:12];
        dec.rd    = instr[11:7];
        dec.rs1   = instr[19:15];
        dec.rs2   = instr[24:20];
    end
endmodule

// File: rtl/mulf_pair_match.sv
// Pair rule: upper multiply in slot 0, lower multiply in slot 1, same
// sources in the same order, upper destination not aliasing a source.
// Assumes both slots are valid only when the caller says so.
module mulf_pair_match
    import mulf_pkg::*;
(
    input  logic   v0,
    input  logic   v1,
    input  mdec_t  d0,
    input  mdec_t  d1,
    output logic   fuse,
    output hmode_e mode
);
    logic hi_ok;
    logic lo_ok;

    // Map the upper-multiply funct3 onto a signedness mode.
    always_comb begin
        hi_ok = d0.muldv;
        mode  = MODE_SS;
        case (d0.f3)
            3'b001:  mode = MODE_SS;
            3'b011:  mode = MODE_UU;
            3'b010:  mode = MODE_SU;
            default: hi_ok = 1'b0;
        endcase
    end

    // Check the lower instruction and the operand rules.
    always_comb begin
        lo_ok = d1.muldv && (d1.f3 == 3'b000);
        fuse  = v0 && v1 && hi_ok && lo_ok
             && (d0.rs1 == d1.rs1) && (d0.rs2 == d1.rs2)
             && (d0.rd != d0.rs1) && (d0.rd != d0.rs2);
    end
endmodule

// File: rtl/mulf_fuse_top.sv
// Decode-stage multiply-pair fuser. Examines two slots per cycle and
// issues a registered micro-op one cycle later: either the fused
// upper/lower pair or the slot-0 instruction alone.
module mulf_fuse_top
    import mulf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot0_valid,
    input  logic [ILEN-1:0]   slot0_instr,
    input  logic              slot1_valid,
    input  logic [ILEN-1:0]   slot1_instr,
    output logic              out_valid,
    output logic              out_fused,
    output logic [1:0]        out_consume,
    output logic [ILEN-1:0]   out_instr,
    output logic [RIDX_W-1:0] out_rd_hi,
    output logic [RIDX_W-1:0] out_rd_lo,
    output logic [1:0]        out_mode,
    output logic              out_lo_wr
);
    mdec_t  dec0;
    mdec_t  dec1;
    logic   fuse;
    hmode_e mode;

    mulf_decode u_dec0 (.instr(slot0_instr), .dec(dec0));
    mulf_decode u_dec1 (.instr(slot1_instr), .dec(dec1));

    mulf_pair_match u_match (
        .v0(slot0_valid), .v1(slot1_valid),
        .d0(dec0), .d1(dec1),
        .fuse(fuse), .mode(mode)
    );

    // Register the issued micro-op; clear everything on reset or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !slot0_valid) begin
            out_valid   <= 1'b0;
            out_fused   <= 1'b0;
            out_consume <= 2'd0;
            out_instr   <= '0;
            out_rd_hi   <= '0;
            out_rd_lo   <= '0;
            out_mode    <= 2'b00;
            out_lo_wr   <= 1'b0;
        end else begin
            out_valid   <= 1'b1;
            out_fused   <= fuse;
            out_consume <= fuse ? 2'd2 : 2'd1;
            out_instr   <= slot0_instr;
            out_rd_hi   <= fuse ? dec0.rd : '0;
            out_rd_lo   <= fuse ? dec1.rd : '0;
            out_mode    <= fuse ? mode : MODE_SS;
            out_lo_wr   <= fuse && (dec1.rd != '0);
        end
    end

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(slot0_valid)));
    // R2
    idle_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_consume == 2'd0));
    // R8
    fuse_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_fused) |-> ($past(slot1_valid) && out_consume == 2'd2));
    // R7
    no_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_fused) |->
            ($past(slot0_instr[11:7]) != $past(slot0_instr[19:15]) &&
             $past(slot0_instr[11:7]) != $past(slot0_instr[24:20])));
    // R10
    lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_lo_wr |-> (out_fused && out_rd_lo != '0));
    // R6
    same_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_fused) |->
            ($past(slot0_instr[24:15]) == $past(slot1_instr[24:15])));
endmodule

// File: tb/mulf_fuse_top_tb_top.sv
module mulf_fuse_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot0_valid = 1'b0;
    logic [31:0] slot0_instr = '0;
    logic        slot1_valid = 1'b0;
    logic [31:0] slot1_instr = '0;
    logic        out_valid, out_fused, out_lo_wr;
    logic [1:0]  out_consume, out_mode;
    logic [31:0] out_instr;
    logic [4:0]  out_rd_hi, out_rd_lo;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // pending expectation for the next falling edge
    bit          armed = 0;
    string       e_tag;
    logic        e_valid, e_fused, e_lo_wr;
    logic [1:0]  e_consume, e_mode;
    logic [31:0] e_instr;
    logic [4:0]  e_hi, e_lo;

    always #2 clk = ~clk;

    mulf_fuse_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .slot0_valid(slot0_valid), .slot0_instr(slot0_instr),
        .slot1_valid(slot1_valid), .slot1_instr(slot1_instr),
        .out_valid(out_valid), .out_fused(out_fused), .out_consume(out_consume),
        .out_instr(out_instr), .out_rd_hi(out_rd_hi), .out_rd_lo(out_rd_lo),
        .out_mode(out_mode), .out_lo_wr(out_lo_wr)
    );

    function automatic logic [31:0] rt(input int f7, input int rs2, input int rs1,
                                       input int f3, input int rd, input int op);
        return {f7[6:0], rs2[4:0], rs1[4:0], f3[2:0], rd[4:0], op[6:0]};
    endfunction

    // behavioural model of the requirements
    task automatic model(input bit rst, input bit v0, input logic [31:0] a,
                         input bit v1, input logic [31:0] b);
        int opa, fa7, fa3, rda, s1a, s2a, opb, fb7, fb3, rdb, s1b, s2b;
        bit hi, lo, f;
        opa = int'(a[6:0]); fa7 = int'(a[31:25]); fa3 = int'(a[14:12]);
        rda = int'(a[11:7]); s1a = int'(a[19:15]); s2a = int'(a[24:20]);
        opb = int'(b[6:0]); fb7 = int'(b[31:25]); fb3 = int'(b[14:12]);
        rdb = int'(b[11:7]); s1b = int'(b[19:15]); s2b = int'(b[24:20]);
        hi = (opa == 51) && (fa7 == 1) && (fa3 >= 1) && (fa3 <= 3);
        lo = (opb == 51) && (fb7 == 1) && (fb3 == 0);
        f  = v0 && v1 && hi && lo && s1a == s1b && s2a == s2b && rda != s1a && rda != s2a;
        if (rst || !v0) begin
            e_valid = 0; e_fused = 0; e_consume = 0; e_instr = 0;
            e_hi = 0; e_lo = 0; e_mode = 0; e_lo_wr = 0;
        end else begin
            e_valid = 1; e_fused = f; e_consume = f ? 2 : 1; e_instr = a;
            e_hi = f ? rda[4:0] : 0; e_lo = f ? rdb[4:0] : 0;
            e_mode = !f ? 2'b00 : (fa3 == 1 ? 2'b00 : (fa3 == 3 ? 2'b01 : 2'b10));
            e_lo_wr = f && rdb != 0;
        end
    endtask

    task automatic step(input bit rst, input bit v0, input logic [31:0] a,
                        input bit v1, input logic [31:0] b, input string tag);
        @(negedge clk);
        if (armed) begin
            checks++;
            if (out_valid !== e_valid || out_fused !== e_fused || out_consume !== e_consume ||
                out_instr !== e_instr || out_rd_hi !== e_hi || out_rd_lo !== e_lo ||
                out_mode !== e_mode || out_lo_wr !== e_lo_wr) begin
                errors++;
                $display("FAIL %s: got v=%0b f=%0b c=%0d i=%h hi=%0d lo=%0d m=%0d w=%0b exp v=%0b f=%0b c=%0d i=%h hi=%0d lo=%0d m=%0d w=%0b",
                    e_tag, out_valid, out_fused, out_consume, out_instr, out_rd_hi, out_rd_lo,
                    out_mode, out_lo_wr, e_valid, e_fused, e_consume, e_instr, e_hi, e_lo,
                    e_mode, e_lo_wr);
            end
        end
        rst_n = !rst; slot0_valid = v0; slot0_instr = a; slot1_valid = v1; slot1_instr = b;
        model(rst, v0, a, v1, b);
        e_tag = tag;
        armed = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        // R1 reset with live-looking inputs
        step(1, 1, rt(1,2,1,1,5,51), 1, rt(1,2,1,0,6,51), "R1");
        step(1, 1, rt(1,2,1,1,5,51), 1, rt(1,2,1,0,6,51), "R1");
        // R2 idle
        step(0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R2");
        // R3 signed x signed
        step(0, 1, rt(1,2,1,1,5,51), 1, rt(1,2,1,0,6,51), "R3");
        // R4 unsigned x unsigned
        step(0, 1, rt(1,4,3,3,9,51), 1, rt(1,4,3,0,10,51), "R4");
        // R5 signed x unsigned
        step(0, 1, rt(1,8,7,2,12,51), 1, rt(1,8,7,0,13,51), "R5");
        // R6 swapped / different sources
        step(0, 1, rt(1,2,1,1,5,51), 1, rt(1,1,2,0,6,51), "R6");
        step(0, 1, rt(1,2,1,1,5,51), 1, rt(1,3,1,0,6,51), "R6");
        // R7 aliasing rd_hi
        step(0, 1, rt(1,2,1,1,1,51), 1, rt(1,2,1,0,6,51), "R7");
        step(0, 1, rt(1,2,1,3,2,51), 1, rt(1,2,1,0,6,51), "R7");
        // R8 slot1 not valid
        step(0, 1, rt(1,2,1,1,5,51), 0, rt(1,2,1,0,6,51), "R8");
        // R9 order, wrong funct3/opcode/funct7
        step(0, 1, rt(1,2,1,0,6,51), 1, rt(1,2,1,1,5,51), "R9");
        step(0, 1, rt(1,2,1,4,5,51), 1, rt(1,2,1,0,6,51), "R9");
        step(0, 1, rt(0,2,1,0,5,51), 1, rt(1,2,1,0,6,51), "R9");
        step(0, 1, rt(1,2,1,1,5,51), 1, rt(0,2,1,0,6,51), "R9");
        step(0, 1, rt(1,2,1,1,5,59), 1, rt(1,2,1,0,6,51), "R9");
        // R10 lower destination x0
        step(0, 1, rt(1,2,1,1,5,51), 1, rt(1,2,1,0,0,51), "R10");
        // R11 pass-through of a plain instruction
        step(0, 1, 32'h00a58533, 1, 32'h00000013, "R11");
        // R12 slot0 empty
        step(0, 0, rt(1,2,1,1,5,51), 1, rt(1,2,1,0,6,51), "R12");
        // random pairs from a small register pool (R3/R6/R7/R11)
        for (int k = 0; k < 400; k++) begin
            int f3a, rda, s1, s2, s1b, s2b, rdb, f7a, f7b;
            f3a = $urandom % 4;
            rda = $urandom % 4; rdb = $urandom % 4;
            s1 = $urandom % 4; s2 = $urandom % 4;
            s1b = ($urandom % 3 == 0) ? $urandom % 4 : s1;
            s2b = ($urandom % 3 == 0) ? $urandom % 4 : s2;
            f7a = ($urandom % 8 == 0) ? 0 : 1;
            f7b = ($urandom % 8 == 0) ? 0 : 1;
            step(0, ($urandom % 6) != 0, rt(f7a, s2, s1, f3a, rda, 51),
                 ($urandom % 6) != 0, rt(f7b, s2b, s1b, $urandom % 2, rdb, 51), "R3/R6/R7/R11 random");
        end
        step(0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R2");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule